// File: doc/BRIEF.md
# Receive-Enable Training Sequencer

This block steers one pass of receive-enable training for a single rank of a DDR channel. A start pulse with a rank number kicks it off. It first selects the DIMM that holds the rank and asks a seed calculator to load per-lane starting delays. When that handshake completes it captures the gross-difference term the seed calculator reports for every byte lane. It then raises the PHY's training-enable level and asks a read engine for a fixed number of back-to-back read bursts, so that the PHY sees a continuous run of strobe edges. After the last burst is acknowledged it holds training enabled for a fixed number of memory clocks, and then drops it.

With training off, the block takes the PHY-measured delays as a valid/ready stream with one beat per byte lane, in lane order. Each beat is combined with the stored gross term and a one-unit-interval offset to give the lane's final receive-enable delay. The largest final delay of the pass is kept, so that a max-latency setting can be derived from it. A single-cycle done pulse closes the pass. The per-lane results and the maximum then hold until the next accepted start.

Top module: `rxen_train_seq`

## Requirements
- R1: A start pulse is accepted only while busy is low. An accepted start sets busy, and at the same edge loads the DIMM select with the rank number shifted right by one. The seed request rises one cycle later. A start seen while busy is high (including the done cycle) changes nothing.
- R2: The seed request stays high until a cycle with seed acknowledge. At that edge the per-lane gross terms are captured, with lane k at bits [k*10 +: 10] of the gross input. Acknowledges outside the request are ignored.
- R3: Training enable rises the cycle after the seed handshake, so all seeds are loaded first. It stays high through the whole burst phase and the wait phase.
- R4: The read request rises together with training enable and stays high until three acknowledges have been seen. The burst count advances only in cycles where request and acknowledge are both high.
- R5: After the cycle of the third read acknowledge, training enable stays high for exactly 200 further cycles, then goes low.
- R6: The measurement ready is high only after training enable has dropped, and it stays high until eight beats are accepted. A beat transfers when valid and ready are both high. The k-th accepted beat belongs to lane k. The source may raise valid early, and it must hold valid and data until the beat is taken.
- R7: For each lane, result = measured delay + (gross term AND 0x1E0) + 0x20, as a 10-bit value. Lane k is at bits [k*10 +: 10] of the result output.
- R8: The maximum output is cleared at an accepted start. It is raised at each accepted beat whose final delay exceeds it, so after done it equals the largest lane result of the pass.
- R9: Done is high for exactly one cycle, the cycle after the eighth beat is taken. Busy returns low the cycle after done.
- R10: The lane results change only at edges where a measurement beat is accepted.
- R11: Under reset, every request, enable, ready, busy and done output is low, and the DIMM select, the results and the maximum are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for one training pass |
| rank_i | input | 3 | Rank to train |
| dimm_sel_o | output | 3 | DIMM select, rank shifted right by one |
| seed_req_o | output | 1 | Seed-load request to the seed calculator |
| seed_ack_i | input | 1 | Seed calculator finished loading seeds |
| gross_diff_i | input | 80 | Per-lane stored gross-difference terms, 10 bits per lane |
| train_en_o | output | 1 | Training-enable level to the PHY |
| rd_req_o | output | 1 | Read-burst request to the read engine |
| rd_ack_i | input | 1 | Read engine accepted one burst |
| meas_valid_i | input | 1 | Measured-delay beat valid |
| meas_ready_o | output | 1 | Block can take a measured-delay beat |
| meas_dly_i | input | 8 | PHY-measured delay for the current lane |
| busy_o | output | 1 | A training pass is in progress |
| done_o | output | 1 | One-cycle pass-complete pulse |
| rxen_dly_o | output | 80 | Final per-lane receive-enable delays, 10 bits per lane |
| max_dly_o | output | 10 | Largest final delay of the pass |

## Verification
A new start pulse can land in the same cycle as the done pulse of the pass before it. That start must be dropped, because busy is still high while done is shown. The bench forces this case by raising start in the cycle its model reports done. It then checks on every clock that busy falls, that the DIMM select and maximum keep their values, and that no seed request follows. The cycle where the last measured beat is taken also overlaps the final result and maximum update. The bench judges this through the done timing and through fixed corner values whose results are known in advance.

// File: rtl/rxen_train_pkg.sv
package rxen_train_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SEL     = 3'd1,
    ST_SEED    = 3'd2,
    ST_BURST   = 3'd3,
    ST_WAIT    = 3'd4,
    ST_COLLECT = 3'd5,
    ST_DONE    = 3'd6
  } rxen_state_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/rxen_seq_ctrl.sv
module rxen_seq_ctrl
  import rxen_train_pkg::*;
#(
  parameter int unsigned LANES    = 8,
  parameter int unsigned BURSTS   = 3,
  parameter int unsigned WAIT_CYC = 200
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       seed_ack_i,
  input  logic                       rd_ack_i,
  input  logic                       meas_valid_i,
  output logic                       seed_req_o,
  output logic                       train_en_o,
  output logic                       rd_req_o,
  output logic                       meas_ready_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       start_take_o,
  output logic                       seed_take_o,
  output logic                       beat_take_o,
  output logic [$clog2(LANES)-1:0]   lane_idx_o
);

  localparam int unsigned BCNT_W = cnt_width(BURSTS);
  localparam int unsigned WCNT_W = cnt_width(WAIT_CYC);
  localparam int unsigned LIDX_W = $clog2(LANES);

  localparam logic [BCNT_W-1:0] BCNT_LAST = BCNT_W'(BURSTS - 1);
  localparam logic [WCNT_W-1:0] WCNT_LAST = WCNT_W'(WAIT_CYC - 1);
  localparam logic [LIDX_W-1:0] LIDX_LAST = LIDX_W'(LANES - 1);

  rxen_state_e         state_q, state_d;
  logic [BCNT_W-1:0]   bcnt_q;
  logic [WCNT_W-1:0]   wcnt_q;
  logic [LIDX_W-1:0]   lidx_q;

  logic burst_ack;
  logic burst_last;
  logic wait_last;
  logic beat_last;

  assign start_take_o = (state_q == ST_IDLE)    && start_i;
  assign seed_take_o  = (state_q == ST_SEED)    && seed_ack_i;
  assign burst_ack    = (state_q == ST_BURST)   && rd_ack_i;
  assign beat_take_o  = (state_q == ST_COLLECT) && meas_valid_i;

  assign burst_last = burst_ack && (bcnt_q == BCNT_LAST);
  assign wait_last  = (state_q == ST_WAIT) && (wcnt_q == WCNT_LAST);
  assign beat_last  = beat_take_o && (lidx_q == LIDX_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i)     state_d = ST_SEL;
      ST_SEL:                      state_d = ST_SEED;
      ST_SEED:    if (seed_ack_i)  state_d = ST_BURST;
      ST_BURST:   if (burst_last)  state_d = ST_WAIT;
      ST_WAIT:    if (wait_last)   state_d = ST_COLLECT;
      ST_COLLECT: if (beat_last)   state_d = ST_DONE;
      ST_DONE:                     state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // burst counter: cleared at the seed handshake, moves only on acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt_q <= '0;
    end else if (seed_take_o) begin
      bcnt_q <= '0;
    end else if (burst_ack && !burst_last) begin
      bcnt_q <= bcnt_q + 1'b1;
    end
  end

  // wait counter: cleared on the last burst, counts every wait cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt_q <= '0;
    end else if (burst_last) begin
      wcnt_q <= '0;
    end else if ((state_q == ST_WAIT) && !wait_last) begin
      wcnt_q <= wcnt_q + 1'b1;
    end
  end

  // lane pointer for the measurement stream
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lidx_q <= '0;
    end else if (wait_last) begin
      lidx_q <= '0;
    end else if (beat_take_o && !beat_last) begin
      lidx_q <= lidx_q + 1'b1;
    end
  end

  assign seed_req_o   = (state_q == ST_SEED);
  assign rd_req_o     = (state_q == ST_BURST);
  assign train_en_o   = (state_q == ST_BURST) || (state_q == ST_WAIT);
  assign meas_ready_o = (state_q == ST_COLLECT);
  assign done_o       = (state_q == ST_DONE);
  assign busy_o       = (state_q != ST_IDLE);
  assign lane_idx_o   = lidx_q;

endmodule

// File: rtl/rxen_lane_bank.sv
module rxen_lane_bank #(
  parameter int unsigned       LANES      = 8,
  parameter int unsigned       MEAS_W     = 8,
  parameter int unsigned       DLY_W      = 10,
  parameter logic [DLY_W-1:0]  GROSS_MASK = 10'h1E0,
  parameter logic [DLY_W-1:0]  UI_OFS     = 10'h020
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          seed_take_i,
  input  logic [LANES*DLY_W-1:0]        gross_i,
  input  logic                          beat_take_i,
  input  logic [$clog2(LANES)-1:0]      lane_idx_i,
  input  logic [MEAS_W-1:0]             meas_i,
  output logic [DLY_W-1:0]              beat_val_o,
  output logic [LANES*DLY_W-1:0]        result_o
);

  localparam int unsigned LIDX_W = $clog2(LANES);

  logic [LANES-1:0][DLY_W-1:0] gross_q;
  logic [LANES-1:0][DLY_W-1:0] final_d;
  logic [LANES-1:0][DLY_W-1:0] res_q;
  logic [DLY_W-1:0]            meas_ext;

  assign meas_ext = DLY_W'(meas_i);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic lane_hit;

    assign lane_hit   = beat_take_i && (lane_idx_i == LIDX_W'(k));
    assign final_d[k] = meas_ext + (gross_q[k] & GROSS_MASK) + UI_OFS;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        gross_q[k] <= '0;
      end else if (seed_take_i) begin
        gross_q[k] <= gross_i[k*DLY_W +: DLY_W];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_q[k] <= '0;
      end else if (lane_hit) begin
        res_q[k] <= final_d[k];
      end
    end

    assign result_o[k*DLY_W +: DLY_W] = res_q[k];
  end

  assign beat_val_o = final_d[lane_idx_i];

endmodule

// File: rtl/rxen_max_track.sv
module rxen_max_track #(
  parameter int unsigned DLY_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             update_i,
  input  logic [DLY_W-1:0] value_i,
  output logic [DLY_W-1:0] max_o
);

  logic [DLY_W-1:0] max_q;
  logic             bigger;

  assign bigger = value_i > max_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      max_q <= '0;
    end else if (clear_i) begin
      max_q <= '0;
    end else if (update_i && bigger) begin
      max_q <= value_i;
    end
  end

  assign max_o = max_q;

endmodule

// File: rtl/rxen_train_seq.sv
module rxen_train_seq #(
  parameter int unsigned RANK_W   = 3,
  parameter int unsigned LANES    = 8,
  parameter int unsigned MEAS_W   = 8,
  parameter int unsigned DLY_W    = 10,
  parameter int unsigned BURSTS   = 3,
  parameter int unsigned WAIT_CYC = 200
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [RANK_W-1:0]       rank_i,
  output logic [RANK_W-1:0]       dimm_sel_o,
  output logic                    seed_req_o,
  input  logic                    seed_ack_i,
  input  logic [LANES*DLY_W-1:0]  gross_diff_i,
  output logic                    train_en_o,
  output logic                    rd_req_o,
  input  logic                    rd_ack_i,
  input  logic                    meas_valid_i,
  output logic                    meas_ready_o,
  input  logic [MEAS_W-1:0]       meas_dly_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [LANES*DLY_W-1:0]  rxen_dly_o,
  output logic [DLY_W-1:0]        max_dly_o
);

  localparam int unsigned LIDX_W = $clog2(LANES);
  localparam logic [DLY_W-1:0] GROSS_MASK = DLY_W'(10'h1E0);
  localparam logic [DLY_W-1:0] UI_OFS     = DLY_W'(10'h020);

  logic              start_take;
  logic              seed_take;
  logic              beat_take;
  logic [LIDX_W-1:0] lane_idx;
  logic [DLY_W-1:0]  beat_val;
  logic [RANK_W-1:0] dimm_q;

  // DIMM select follows the accepted rank before anything else happens
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dimm_q <= '0;
    end else if (start_take) begin
      dimm_q <= rank_i >> 1;
    end
  end

  assign dimm_sel_o = dimm_q;

  rxen_seq_ctrl #(
    .LANES    (LANES),
    .BURSTS   (BURSTS),
    .WAIT_CYC (WAIT_CYC)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .seed_ack_i   (seed_ack_i),
    .rd_ack_i     (rd_ack_i),
    .meas_valid_i (meas_valid_i),
    .seed_req_o   (seed_req_o),
    .train_en_o   (train_en_o),
    .rd_req_o     (rd_req_o),
    .meas_ready_o (meas_ready_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .start_take_o (start_take),
    .seed_take_o  (seed_take),
    .beat_take_o  (beat_take),
    .lane_idx_o   (lane_idx)
  );

  rxen_lane_bank #(
    .LANES      (LANES),
    .MEAS_W     (MEAS_W),
    .DLY_W      (DLY_W),
    .GROSS_MASK (GROSS_MASK),
    .UI_OFS     (UI_OFS)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .seed_take_i (seed_take),
    .gross_i     (gross_diff_i),
    .beat_take_i (beat_take),
    .lane_idx_i  (lane_idx),
    .meas_i      (meas_dly_i),
    .beat_val_o  (beat_val),
    .result_o    (rxen_dly_o)
  );

  rxen_max_track #(
    .DLY_W (DLY_W)
  ) u_max (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start_take),
    .update_i (beat_take),
    .value_i  (beat_val),
    .max_o    (max_dly_o)
  );

endmodule

// File: rtl/rxen_train_seq_chk.sv
module rxen_train_seq_chk #(
  parameter int unsigned RANK_W   = 3,
  parameter int unsigned LANES    = 8,
  parameter int unsigned DLY_W    = 10,
  parameter int unsigned WAIT_CYC = 200
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic [RANK_W-1:0]      dimm_sel_o,
  input logic                   seed_req_o,
  input logic                   seed_ack_i,
  input logic                   train_en_o,
  input logic                   rd_req_o,
  input logic                   rd_ack_i,
  input logic                   meas_valid_i,
  input logic                   meas_ready_o,
  input logic                   busy_o,
  input logic                   done_o,
  input logic [LANES*DLY_W-1:0] rxen_dly_o
);

  logic [31:0] wait_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_seen <= '0;
    end else if (!train_en_o) begin
      wait_seen <= '0;
    end else if (!rd_req_o) begin
      wait_seen <= wait_seen + 1'b1;
    end
  end

  // R1
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(dimm_sel_o));

  // R2
  seed_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_req_o && !seed_ack_i) |=> seed_req_o);

  // R3
  enable_after_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_en_o) |-> $past(seed_req_o && seed_ack_i));

  // R4
  read_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> rd_req_o);

  // R5
  wait_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(train_en_o) |-> (wait_seen == WAIT_CYC));

  // R6
  ready_after_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_ready_o |-> !train_en_o);

  // R6
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seed_req_o, rd_req_o, meas_ready_o, done_o}));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R10
  results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_valid_i && meas_ready_o) |=> $stable(rxen_dly_o));

endmodule

bind rxen_train_seq rxen_train_seq_chk #(
  .RANK_W   (RANK_W),
  .LANES    (LANES),
  .DLY_W    (DLY_W),
  .WAIT_CYC (WAIT_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .dimm_sel_o   (dimm_sel_o),
  .seed_req_o   (seed_req_o),
  .seed_ack_i   (seed_ack_i),
  .train_en_o   (train_en_o),
  .rd_req_o     (rd_req_o),
  .rd_ack_i     (rd_ack_i),
  .meas_valid_i (meas_valid_i),
  .meas_ready_o (meas_ready_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .rxen_dly_o   (rxen_dly_o)
);

// File: tb/rxen_train_seq_test.sv
module rxen_train_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int RANK_W = 3;
  localparam int LANES  = 8;
  localparam int MEAS_W = 8;
  localparam int DLY_W  = 10;
  localparam int NBURST = 3;
  localparam int NWAIT  = 200;
  localparam int WDOG   = 150000;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   start_i = 1'b0;
  logic [RANK_W-1:0]      rank_i = '0;
  logic [RANK_W-1:0]      dimm_sel_o;
  logic                   seed_req_o;
  logic                   seed_ack_i = 1'b0;
  logic [LANES*DLY_W-1:0] gross_diff_i = '0;
  logic                   train_en_o;
  logic                   rd_req_o;
  logic                   rd_ack_i = 1'b0;
  logic                   meas_valid_i = 1'b0;
  logic                   meas_ready_o;
  logic [MEAS_W-1:0]      meas_dly_i = '0;
  logic                   busy_o;
  logic                   done_o;
  logic [LANES*DLY_W-1:0] rxen_dly_o;
  logic [DLY_W-1:0]       max_dly_o;

  rxen_train_seq uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .rank_i       (rank_i),
    .dimm_sel_o   (dimm_sel_o),
    .seed_req_o   (seed_req_o),
    .seed_ack_i   (seed_ack_i),
    .gross_diff_i (gross_diff_i),
    .train_en_o   (train_en_o),
    .rd_req_o     (rd_req_o),
    .rd_ack_i     (rd_ack_i),
    .meas_valid_i (meas_valid_i),
    .meas_ready_o (meas_ready_o),
    .meas_dly_i   (meas_dly_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .rxen_dly_o   (rxen_dly_o),
    .max_dly_o    (max_dly_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // reference model state (phase: 0 idle, 1 select, 2 seed, 3 bursts, 4 wait, 5 collect, 6 done)
  int m_phase = 0;
  int m_bursts = 0;
  int m_waited = 0;
  int m_lane = 0;
  int m_dimm = 0;
  int m_max = 0;
  int m_gross[LANES];
  int m_res[LANES];
  bit m_took = 0;

  int vectors = 0;
  int misses = 0;
  int cycles = 0;

  // stimulus knobs set by the sequence
  bit          fixed_mode = 0;
  bit          start_req = 0;
  bit          done_poke = 0;
  int          req_rank = 0;
  logic [31:0] rnd = 32'h1234_5679;
  int          fixed_meas[LANES];
  int          fixed_gross[LANES];

  function automatic int lane_final(input int meas, input int gross);
    return (meas + (gross & 'h1E0) + 'h20) & 'h3FF;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0h expected %0h at t=%0t", req, what, act, exp, $time);
    end
  endtask

  // reference model update
  always @(posedge clk) begin
    m_took = 0;
    if (!rst_n) begin
      m_phase = 0; m_bursts = 0; m_waited = 0; m_lane = 0;
      m_dimm = 0; m_max = 0;
      for (int k = 0; k < LANES; k++) begin m_gross[k] = 0; m_res[k] = 0; end
    end else begin
      case (m_phase)
        0: if (start_i) begin
             m_phase = 1; m_dimm = int'(rank_i) / 2; m_max = 0;
           end
        1: m_phase = 2;
        2: if (seed_ack_i) begin
             for (int k = 0; k < LANES; k++) m_gross[k] = int'(gross_diff_i[k*DLY_W +: DLY_W]);
             m_phase = 3; m_bursts = 0;
           end
        3: if (rd_ack_i) begin
             m_bursts++;
             if (m_bursts == NBURST) begin m_phase = 4; m_waited = 0; end
           end
        4: begin
             m_waited++;
             if (m_waited == NWAIT) begin m_phase = 5; m_lane = 0; end
           end
        5: if (meas_valid_i) begin
             m_res[m_lane] = lane_final(int'(meas_dly_i), m_gross[m_lane]);
             if (m_res[m_lane] > m_max) m_max = m_res[m_lane];
             m_lane++;
             m_took = 1;
             if (m_lane == LANES) m_phase = 6;
           end
        6: m_phase = 0;
        default: m_phase = 0;
      endcase
    end
  end

  // compare on every clock, then drive the next inputs
  always @(negedge clk) begin
    cycles++;
    check("R1", "busy", int'(busy_o), int'(m_phase != 0));
    check("R1", "dimm_sel", int'(dimm_sel_o), m_dimm);
    check("R2", "seed_req", int'(seed_req_o), int'(m_phase == 2));
    check("R3", "train_en", int'(train_en_o), int'(m_phase == 3 || m_phase == 4));
    check("R4", "rd_req", int'(rd_req_o), int'(m_phase == 3));
    check("R6", "meas_ready", int'(meas_ready_o), int'(m_phase == 5));
    check("R9", "done", int'(done_o), int'(m_phase == 6));
    check("R8", "max_dly", int'(max_dly_o), m_max);
    for (int k = 0; k < LANES; k++)
      check("R7", $sformatf("lane%0d", k), int'(rxen_dly_o[k*DLY_W +: DLY_W]), m_res[k]);
    if (cycles > WDOG) begin
      misses++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end

    rnd = rnd ^ (rnd << 13);
    rnd = rnd ^ (rnd >> 17);
    rnd = rnd ^ (rnd << 5);

    // start, with stray pulses while busy in random mode
    start_i = 1'b0;
    if (start_req && rst_n) begin
      start_i = 1'b1; rank_i = RANK_W'(req_rank); start_req = 0;
    end else if (done_poke && m_phase == 6) begin
      start_i = 1'b1; rank_i = RANK_W'(req_rank + 3); done_poke = 0;
    end else if (!fixed_mode && m_phase != 0 && rnd[15:11] == 5'd0) begin
      start_i = 1'b1; rank_i = RANK_W'(rnd[18:16]);
    end

    if (fixed_mode) begin
      seed_ack_i = (m_phase == 2);
      rd_ack_i   = (m_phase == 3);
      for (int k = 0; k < LANES; k++) gross_diff_i[k*DLY_W +: DLY_W] = DLY_W'(fixed_gross[k]);
      meas_valid_i = 1'b1;
      meas_dly_i   = MEAS_W'(fixed_meas[(m_lane < LANES) ? m_lane : 0]);
    end else begin
      seed_ack_i   = rnd[3];
      rd_ack_i     = rnd[5] & rnd[6];
      gross_diff_i = {rnd[19:0], rnd[31:12], rnd[29:10], rnd[27:8]};
      if (!meas_valid_i || m_took) begin
        meas_valid_i = rnd[0] | rnd[1];
        meas_dly_i   = rnd[9:2];
      end
    end
  end

  task automatic wait_idle();
    bit seen = 0;
    while (!(seen && m_phase == 0)) begin
      @(posedge clk); #1;
      if (m_phase != 0) seen = 1;
    end
  endtask

  initial begin
    for (int k = 0; k < LANES; k++) begin
      fixed_meas[k]  = 'h11 * k;
      fixed_gross[k] = 'h45 * k;
    end
    fixed_meas[0] = 'hFF; fixed_gross[0] = 'h3FF;
    fixed_meas[1] = 'h00; fixed_gross[1] = 'h01F;

    repeat (3) @(posedge clk);
    #1;
    // R11: reset values
    check("R11", "reset busy", int'(busy_o), 0);
    check("R11", "reset train_en", int'(train_en_o), 0);
    check("R11", "reset max", int'(max_dly_o), 0);
    check("R11", "reset results", int'(rxen_dly_o != '0), 0);
    rst_n = 1'b1;

    // directed pass with known corner values
    fixed_mode = 1; req_rank = 5; start_req = 1;
    wait_idle();
    check("R7", "lane0 all gross bits", int'(rxen_dly_o[0 +: DLY_W]), 'h2FF);
    check("R7", "lane1 gross masked out", int'(rxen_dly_o[DLY_W +: DLY_W]), 'h020);
    check("R8", "max of directed pass", int'(max_dly_o), 'h2FF);
    check("R1", "dimm of rank 5", int'(dimm_sel_o), 2);

    // start arriving in the done cycle must be dropped
    fixed_mode = 0; req_rank = 6; start_req = 1; done_poke = 1;
    wait_idle();
    repeat (3) begin
      @(posedge clk); #1;
      check("R9", "start in done cycle ignored", int'(busy_o), 0);
    end
    check("R1", "dimm kept after dropped start", int'(dimm_sel_o), 3);

    // randomized passes with gaps, stray starts and held beats
    for (int r = 0; r < 30; r++) begin
      req_rank = r % 8; start_req = 1;
      wait_idle();
      repeat (r % 4) @(posedge clk);
    end

    #1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule